// File: doc/BRIEF.md
# ADC Conversion Clock Generator

This block produces the bit-period timing for a successive-approximation converter. It gives a gated conversion clock, a bit-period (TAD) square wave, a half-period tick and a full-period tick, and it times one conversion. The conversion clock comes from one of two sources, switched without glitches:

- The system clock, with TAD set to an even division of it. The divide ratio is 2×(code+1), where code is a 6-bit divisor.
- An independent internal oscillator that runs at twice the TAD rate, so each of its cycles is one half-TAD. This source keeps working when the system clock is stopped, as in a low-power sleep state.

A start pulse, taken while idle, does three things. It restarts the divider so that TAD lines up with the conversion. It raises busy for 11.5 TAD (23 half-TAD ticks). It then pulses done for one conversion-clock cycle. The bit logic downstream runs on `conv_clk` and uses the ticks as enables. The source select and the divisor code are followed only while the block is idle, so a conversion never sees its TAD period change.

Top module: `adc_tad_clkgen`

## Requirements
- R1: After reset the block is idle: busy=0, done=0, tad=0. The system-clock source is selected and the divisor code is 0.
- R2: With the system-clock source (src_int=0), half_tick is high once every code+1 conversion-clock cycles. TAD is therefore 2×(code+1) system-clock periods. Code 0 gives /2, code 3 gives /8 and code 63 gives /128.
- R3: tad toggles on every conversion-clock edge at which half_tick is high, so its duty cycle is 50%. tad_tick equals half_tick AND tad, which marks the end of each full TAD period.
- R4: With src_int=1, conv_clk follows int_clk and half_tick is high every cycle, so TAD is two int_clk periods. Conversions complete with sys_clk stopped.
- R5: A start pulse taken while idle clears the divider phase and sets tad to 0. busy is then high for exactly 23 half-TAD ticks, which is 23×(code+1) conversion-clock cycles. busy falls, and done is high for the single following cycle.
- R6: div_code and src_int are sampled only while idle. Changes made while busy do not alter the running conversion.
- R7: A start pulse while busy is ignored, and the conversion length is unchanged.
- R8: On a change of source, the two source enables are never both on, and conv_clk has no high or low phase shorter than the shorter source half-period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock, divided source |
| int_clk | input | 1 | Internal oscillator at twice the TAD rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_int | input | 1 | Source select: 1 internal, 0 system clock |
| div_code | input | 6 | Divisor code, TAD = 2×(code+1) system clocks |
| start | input | 1 | One-cycle conversion start request |
| conv_clk | output | 1 | Glitch-free selected conversion clock |
| tad | output | 1 | TAD square wave, 50% duty |
| half_tick | output | 1 | Half-TAD enable, conv_clk domain |
| tad_tick | output | 1 | Full-TAD enable, conv_clk domain |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle end-of-conversion pulse |

## Verification
The assertions rely on four assumptions about the inputs:

- start, div_code and src_int are synchronous to conv_clk and change only away from its rising edge.
- int_clk runs continuously.
- sys_clk is stopped only after the handover to the internal source has finished.
- The two source clocks have no fixed phase relation.

The stimulus keeps within these limits. It changes every input shortly after a falling edge of conv_clk. It waits several conversion cycles after changing src_int before it gates sys_clk off. It restarts sys_clk before selecting the system-clock source again.

// File: rtl/adc_tad_clkgen.sv
module adc_tad_clkgen #(
  parameter int CODE_W      = 6,
  parameter int CONV_HALVES = 23
) (
  input  logic              sys_clk,
  input  logic              int_clk,
  input  logic              rst_n,
  input  logic              src_int,
  input  logic [CODE_W-1:0] div_code,
  input  logic              start,
  output logic              conv_clk,
  output logic              tad,
  output logic              half_tick,
  output logic              tad_tick,
  output logic              busy,
  output logic              done
);
  localparam int HW = $clog2(CONV_HALVES);
  localparam logic [HW-1:0] LAST_HALF = HW'(CONV_HALVES - 1);

  logic              sel_q;
  logic [CODE_W-1:0] code_q, cnt, lim;
  logic [HW-1:0]     hcnt;
  logic              sys_req, sys_en, int_req, int_en, go;

  // handover: request on rising edge, enable on falling edge of each source
  always_ff @(posedge sys_clk or negedge rst_n)
    if (!rst_n) sys_req <= 1'b0;
    else        sys_req <= ~sel_q & ~int_en;

  always_ff @(negedge sys_clk or negedge rst_n)
    if (!rst_n) sys_en <= 1'b0;
    else        sys_en <= sys_req;

  always_ff @(posedge int_clk or negedge rst_n)
    if (!rst_n) int_req <= 1'b0;
    else        int_req <= sel_q & ~sys_en;

  always_ff @(negedge int_clk or negedge rst_n)
    if (!rst_n) int_en <= 1'b0;
    else        int_en <= int_req;

  assign conv_clk  = (sys_clk & sys_en) | (int_clk & int_en);
  assign lim       = sel_q ? '0 : code_q;
  assign half_tick = cnt >= lim;
  assign tad_tick  = half_tick & tad;
  assign go        = start & ~busy;

  always_ff @(posedge conv_clk or negedge rst_n)
    if (!rst_n) begin
      sel_q  <= 1'b0;
      code_q <= '0;
      cnt    <= '0;
      hcnt   <= '0;
      tad    <= 1'b0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        sel_q  <= src_int;
        code_q <= div_code;
      end
      if (go) begin
        busy <= 1'b1;
        hcnt <= '0;
        cnt  <= '0;
        tad  <= 1'b0;
      end else if (half_tick) begin
        cnt <= '0;
        tad <= ~tad;
        if (busy) begin
          if (hcnt == LAST_HALF) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end

  always_comb
    if (rst_n) AST_ONE_SOURCE: assert (!(sys_en && int_en)); // R8

  AST_TAD_TOGGLE: assert property (@(posedge conv_clk) disable iff (!rst_n)
    half_tick && !go |=> tad != $past(tad)); // R3

  AST_START_ALIGN: assert property (@(posedge conv_clk) disable iff (!rst_n)
    go |=> busy && !tad && !done); // R5

  AST_DONE_AT_END: assert property (@(posedge conv_clk) disable iff (!rst_n)
    done |-> !busy && $past(busy)); // R5

  AST_CFG_FROZEN: assert property (@(posedge conv_clk) disable iff (!rst_n)
    $past(busy) |-> $stable(code_q) && $stable(sel_q)); // R6

  AST_START_IGNORED: assert property (@(posedge conv_clk) disable iff (!rst_n)
    busy && start && !half_tick |=> busy && $stable(hcnt)); // R7
endmodule

// File: tb/test_adc_tad_clkgen.sv
`timescale 1ns/1ps
module test_adc_tad_clkgen;
  logic sys_clk = 0, int_clk = 0, rst_n = 0, src_int = 0, start = 0;
  logic [5:0] div_code = 0;
  logic conv_clk, tad, half_tick, tad_tick, busy, done;
  logic sys_run = 1, chk_on = 0;
  int total = 0, bad = 0;

  adc_tad_clkgen i_adc_tad_clkgen (
    .sys_clk(sys_clk), .int_clk(int_clk), .rst_n(rst_n), .src_int(src_int),
    .div_code(div_code), .start(start), .conv_clk(conv_clk), .tad(tad),
    .half_tick(half_tick), .tad_tick(tad_tick), .busy(busy), .done(done));

  initial forever begin #10; sys_clk = sys_run ? ~sys_clk : 1'b0; end
  initial forever #17 int_clk = ~int_clk;

  // behavioural reference, advanced on each rising edge of conv_clk
  int m_cnt = 0, m_left = 0, m_code = 0;
  bit m_tad = 0, m_done = 0, m_sel = 0, m_half, m_was_busy;

  function automatic bit exp_half();
    return m_cnt >= (m_sel ? 0 : m_code);
  endfunction

  always @(posedge conv_clk or negedge rst_n)
    if (!rst_n) begin
      m_cnt = 0; m_left = 0; m_code = 0; m_tad = 0; m_done = 0; m_sel = 0;
    end else begin
      m_half = exp_half();
      m_was_busy = m_left > 0;
      m_done = 0;
      if (!m_was_busy && start) begin
        m_left = 23; m_cnt = 0; m_tad = 0;
      end else if (m_half) begin
        m_cnt = 0; m_tad = ~m_tad;
        if (m_left > 0) begin
          m_left--;
          if (m_left == 0) m_done = 1;
        end
      end else m_cnt++;
      if (!m_was_busy) begin m_code = div_code; m_sel = src_int; end
    end

  always @(negedge conv_clk)
    if (rst_n && chk_on) begin
      total++;
      if (busy !== (m_left > 0) || done !== m_done || tad !== m_tad ||
          half_tick !== exp_half() || tad_tick !== (exp_half() & m_tad)) begin
        bad++;
        $display("FAIL R2 R3 R5 model: busy/done/tad/half/tadtick=%b%b%b%b%b expected %b%b%b%b%b",
                 busy, done, tad, half_tick, tad_tick,
                 m_left > 0, m_done, m_tad, exp_half(), exp_half() & m_tad);
      end
    end

  // narrowest conv_clk phase, for R8
  realtime last_edge = -1.0, min_w = 1.0e9;
  always @(conv_clk)
    if (rst_n) begin
      if (last_edge >= 0 && $realtime - last_edge < min_w) min_w = $realtime - last_edge;
      last_edge = $realtime;
    end

  realtime t_rise, t_fall;
  always @(posedge busy) t_rise = $realtime;
  always @(negedge busy) t_fall = $realtime;

  task automatic check(input bit ok, input string what, input real act, input real exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual %0.2f expected %0.2f", what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge conv_clk);
    #1;
  endtask

  task automatic pulse_start();
    cyc(1); start = 1;
    cyc(1); start = 0;
  endtask

  task automatic tad_period(input real exp, input string what);
    realtime a, b;
    repeat (2) @(posedge tad);
    a = $realtime;
    @(posedge tad);
    b = $realtime;
    check(b - a > exp - 0.01 && b - a < exp + 0.01, what, b - a, exp);
  endtask

  // mode 1: change code mid-run (R6), mode 2: extra start mid-run (R7)
  task automatic conv(input int code, input real exp, input int mode, input string what);
    div_code = 6'(code);
    cyc(3);
    pulse_start();
    if (mode == 1) begin cyc(5); div_code = 6'(code ^ 6'h15); src_int = ~src_int; end
    if (mode == 2) begin cyc(7); start = 1; cyc(1); start = 0; end
    @(negedge busy);
    @(negedge conv_clk);
    check(done === 1'b1, {what, " done"}, done, 1);
    check(t_fall - t_rise > exp - 0.01 && t_fall - t_rise < exp + 0.01, what, t_fall - t_rise, exp);
    if (mode == 1) begin src_int = ~src_int; div_code = 6'(code); end
    cyc(1);
  endtask

  initial begin
    #55;
    check(busy === 0 && done === 0 && tad === 0 && conv_clk === 0, "R1 reset state", busy, 0);
    rst_n = 1;
    chk_on = 1;
    tad_period(40.0, "R1 R2 default /2 after reset");
    div_code = 3; tad_period(160.0, "R2 code 3 /8");
    div_code = 7; tad_period(320.0, "R2 code 7 /16");
    div_code = 63; tad_period(2560.0, "R2 code 63 /128");
    conv(0, 460.0, 0, "R5 code 0 length");
    conv(1, 920.0, 0, "R5 code 1 length");
    conv(63, 29440.0, 0, "R5 code 63 length");
    conv(2, 1380.0, 1, "R6 cfg change while busy");
    conv(4, 2300.0, 2, "R7 start while busy");
    src_int = 1; cyc(10);
    tad_period(68.0, "R4 internal TAD");
    conv(9, 782.0, 0, "R4 internal length");
    sys_run = 0; cyc(4);
    conv(9, 782.0, 2, "R4 R7 sys clock stopped");
    sys_run = 1; cyc(4);
    src_int = 0; div_code = 1; cyc(10);
    tad_period(80.0, "R8 back to system /4");
    src_int = 1; cyc(6); src_int = 0; cyc(6); src_int = 1; cyc(10);
    conv(0, 782.0, 0, "R8 after repeated handovers");
    src_int = 0; cyc(10);
    check(min_w > 9.99, "R8 narrowest conv_clk phase", min_w, 10.0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #3_000_000;
    bad++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule